// File: doc/BRIEF.md
# Chunked Tile Matrix-Multiply Engine

This engine computes Z = Mat1 * Mat2 on signed 16-bit fixed-point matrices held in a chunk-major layout. A chunk is 32 elements of 16 bits (512 bits), and one chunk moves per transfer. A grid of 8 x 32 multiply-accumulate elements works on one 8-row by 32-column tile of Z at a time. On every step it takes one column of the buffered Mat1 sub-matrix, eight values sent along the rows, and one 32-element row chunk of Mat2, sent down the columns. Each element adds one product to its own accumulator.

Mat1 arrives as sub-matrices of 8 rows by 32 elements, one row chunk per beat. The sub-matrices go into a two-half buffer, so the next one can load while the current one is in use. Mat2 arrives as one chunk per beat, walking down its rows. The partial sums stay in the element registers until every Mat2 row for the tile has been consumed. The tile is then rounded and saturated back to 16 bits, with an optional per-column bias added first, and it leaves as eight row chunks. Matrix sizes, the fraction shift and the bias request are taken when `start` is pulsed.

Top module: `mmt_tile_engine`

## Requirements
- R1: After reset, and while idle, `mat1Ready`, `mat2Ready`, `biasReady`, `outValid`, `outLast` and `done` are all low.
- R2: Element e of every 512-bit chunk sits at bits [16e+15:16e]. Tiles are numbered t = 0 .. (A/8)*(D/32)-1, with row block rb = t mod (A/8) and column chunk cb = t div (A/8). For tile t, Mat1 comes as B/32 sub-matrices in ascending k-block order; each is 8 beats for rows rb*8..rb*8+7 in ascending order, and carries columns kb*32..kb*32+31. Mat2 comes as B beats: for k ascending, row k, columns cb*32..cb*32+31.
- R3: Before rounding, each output element equals the exact sum over k of Mat1[row][k]*Mat2[k][col], held in a 40-bit signed accumulator.
- R4: With fraction shift s (0..15), an output is sat16((acc + 2^(s-1)) >>> s); for s = 0 no rounding term is added. Saturation clamps to 32767 and -32768.
- R5: With the bias request set at start, one bias chunk (chunk cb of the bias vector) is taken per tile after its last Mat2 beat. Bias element e is added to column e at weight 2^s before rounding.
- R6: With the bias request clear, `biasReady` stays low for the whole operation and the results carry no bias.
- R7: Each tile leaves as 8 chunks, tile rows in ascending order, tiles in ascending t (so Z is written chunk-major). `outLast` is high on the eighth chunk only.
- R8: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outLast` hold.
- R9: When both input streams present data on every cycle, the B Mat2 beats of a tile are accepted on consecutive cycles, with no stall at sub-matrix boundaries.
- R10: `mat2Ready` is low while a tile is waiting for its bias or draining its output.
- R11: `done` is a one-cycle pulse in the cycle after the final output chunk is transferred, and it occurs exactly once per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; taken only while idle |
| aTotal | input | DIMW | Rows of Mat1 (multiple of 8) |
| bTotal | input | DIMW | Columns of Mat1 and rows of Mat2 (multiple of 32) |
| dTotal | input | DIMW | Columns of Mat2 (multiple of 32) |
| fracShift | input | 4 | Right shift applied when rounding results |
| biasEn | input | 1 | Request a bias add for every tile |
| mat1Valid | input | 1 | Mat1 chunk valid |
| mat1Ready | output | 1 | Mat1 chunk accepted when valid is also high |
| mat1Data | input | 512 | Mat1 row chunk |
| mat2Valid | input | 1 | Mat2 chunk valid |
| mat2Ready | output | 1 | Mat2 chunk accepted when valid is also high |
| mat2Data | input | 512 | Mat2 row chunk |
| biasValid | input | 1 | Bias chunk valid |
| biasReady | output | 1 | Bias chunk accepted when valid is also high |
| biasData | input | 512 | Bias chunk for the tile's 32 columns |
| outValid | output | 1 | Result chunk valid |
| outReady | input | 1 | Consumer takes the result chunk |
| outData | output | 512 | Result row chunk |
| outLast | output | 1 | Final chunk of the current tile |
| done | output | 1 | Pulse after the last tile of the operation |

## Verification
Small directed matrices with gapless streams check the basic sum of products and the tile-row order. A saturation pattern drives both clamps. A single-product pattern with shift 1 and a small bias hits the round-half cases for positive and negative values and shows the bias weight. Random multi-tile runs with bubbles on every stream and random output back-pressure cover several k-blocks per tile and several tiles. They can tell a wrong buffer half, a lost sub-matrix, a missing accumulator clear between tiles or a wrong tile order from a correct result. A gapless multi-block run without bias shows that the two-half buffer keeps the Mat2 beats back to back, and that the bias handshake stays silent.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  // Tile geometry shared by control and datapath
  localparam int TILE_ROWS   = 8;
  localparam int CHUNK_LANES = 32;
  localparam int ROW_W       = $clog2(TILE_ROWS);
  localparam int LANE_W      = $clog2(CHUNK_LANES);

  // Strobes from control to datapath
  typedef struct packed {
    logic              loadEn;
    logic              loadHalf;
    logic [ROW_W-1:0]  loadRow;
    logic              stepEn;
    logic              stepFirst;
    logic              stepHalf;
    logic [LANE_W-1:0] stepCol;
    logic              biasAdd;
    logic [ROW_W-1:0]  outRow;
    logic [3:0]        fracShift;
  } ctrlStrobes_t;
endpackage

// File: rtl/mmt_pe.sv
module mmt_pe #(
  parameter int EW   = 16,
  parameter int ACCW = 40
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   stepEn,
  input  logic                   stepFirst,
  input  logic                   biasAdd,
  input  logic signed [EW-1:0]   a,
  input  logic signed [EW-1:0]   b,
  input  logic signed [ACCW-1:0] biasTerm,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW = 2 * EW;

  logic signed [PW-1:0] prod;
  assign prod = a * b;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (stepEn) begin
      // the first step of a tile restarts the sum
      acc <= (stepFirst ? '0 : acc) + ACCW'(prod);
    end else if (biasAdd) begin
      acc <= acc + biasTerm;
    end
  end
endmodule

// File: rtl/mmt_datapath.sv
module mmt_datapath import mmt_pkg::*; #(
  parameter int EW   = 16,
  parameter int ACCW = 40
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 ctrl,
  input  logic [CHUNK_LANES*EW-1:0]    mat1Data,
  input  logic [CHUNK_LANES*EW-1:0]    mat2Data,
  input  logic [CHUNK_LANES*EW-1:0]    biasData,
  output logic [CHUNK_LANES*EW-1:0]    outData
);
  localparam int PADW = ACCW - EW + 2;
  localparam logic signed [ACCW:0] SAT_HI = {{PADW{1'b0}}, {(EW-1){1'b1}}};
  localparam logic signed [ACCW:0] SAT_LO = {{PADW{1'b1}}, {(EW-1){1'b0}}};

  // two halves of the Mat1 sub-matrix buffer
  logic [EW-1:0] subBuf [2][TILE_ROWS][CHUNK_LANES];

  logic signed [EW-1:0]   colA     [TILE_ROWS];
  logic signed [EW-1:0]   laneB    [CHUNK_LANES];
  logic signed [ACCW-1:0] biasTerm [CHUNK_LANES];
  logic signed [ACCW-1:0] accArr   [TILE_ROWS][CHUNK_LANES];

  function automatic logic [EW-1:0] roundSat(input logic signed [ACCW-1:0] v,
                                             input logic [3:0] s);
    logic signed [ACCW:0] t;
    logic [ACCW:0] half;
    t    = {v[ACCW-1], v};
    half = '0;
    if (s != 4'd0) half = {{ACCW{1'b0}}, 1'b1} << (s - 4'd1);
    t = t + signed'(half);
    t = t >>> s;
    if (t > SAT_HI) return SAT_HI[EW-1:0];
    if (t < SAT_LO) return SAT_LO[EW-1:0];
    return t[EW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (ctrl.loadEn) begin
      for (int l = 0; l < CHUNK_LANES; l++) begin
        subBuf[ctrl.loadHalf][ctrl.loadRow][l] <= mat1Data[l*EW +: EW];
      end
    end
  end

  for (genvar r = 0; r < TILE_ROWS; r++) begin : g_colA
    assign colA[r] = signed'(subBuf[ctrl.stepHalf][r][ctrl.stepCol]);
  end

  for (genvar l = 0; l < CHUNK_LANES; l++) begin : g_lane
    assign laneB[l]    = signed'(mat2Data[l*EW +: EW]);
    assign biasTerm[l] = ACCW'(signed'(biasData[l*EW +: EW])) <<< ctrl.fracShift;
    assign outData[l*EW +: EW] = roundSat(accArr[ctrl.outRow][l], ctrl.fracShift);
  end

  for (genvar r = 0; r < TILE_ROWS; r++) begin : g_row
    for (genvar l = 0; l < CHUNK_LANES; l++) begin : g_col
      mmt_pe #(.EW(EW), .ACCW(ACCW)) pe_i (
        .clk      (clk),
        .rstN     (rstN),
        .stepEn   (ctrl.stepEn),
        .stepFirst(ctrl.stepFirst),
        .biasAdd  (ctrl.biasAdd),
        .a        (colA[r]),
        .b        (laneB[l]),
        .biasTerm (biasTerm[l]),
        .acc      (accArr[r][l])
      );
    end
  end
endmodule

// File: rtl/mmt_ctrl.sv
module mmt_ctrl import mmt_pkg::*; #(
  parameter int DIMW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [DIMW-1:0] aTotal,
  input  logic [DIMW-1:0] bTotal,
  input  logic [DIMW-1:0] dTotal,
  input  logic [3:0]      fracShift,
  input  logic            biasEn,
  input  logic            mat1Valid,
  output logic            mat1Ready,
  input  logic            mat2Valid,
  output logic            mat2Ready,
  input  logic            biasValid,
  output logic            biasReady,
  output logic            outValid,
  input  logic            outReady,
  output logic            outLast,
  output logic            done,
  output ctrlStrobes_t    ctrl
);
  localparam int CNTW = 3 * DIMW;

  typedef enum logic [1:0] {PH_IDLE, PH_STEP, PH_BIAS, PH_DRAIN} phase_t;

  phase_t            phase;
  logic [CNTW-1:0]   tilesLeft, subsLeft, tilesCalc, subsCalc;
  logic [DIMW-1:0]   bTot, kCount;
  logic [1:0]        halfFull;
  logic              wrHalf, rdHalf, firstStep, biasEnQ, doneQ;
  logic [ROW_W-1:0]  wrRow, outRow;
  logic [LANE_W-1:0] stepCol;
  logic [3:0]        fracQ;
  logic              m1Fire, m2Fire, bFire, oFire, colEnd, lastStep, subEnd;

  assign tilesCalc = CNTW'(aTotal >> ROW_W) * CNTW'(dTotal >> LANE_W);
  assign subsCalc  = tilesCalc * CNTW'(bTotal >> LANE_W);

  assign mat1Ready = (phase != PH_IDLE) && !halfFull[wrHalf] && (subsLeft != '0);
  assign mat2Ready = (phase == PH_STEP) && halfFull[rdHalf];
  assign biasReady = (phase == PH_BIAS);
  assign outValid  = (phase == PH_DRAIN);
  assign outLast   = outValid && (outRow == ROW_W'(TILE_ROWS - 1));
  assign done      = doneQ;

  assign m1Fire   = mat1Valid && mat1Ready;
  assign m2Fire   = mat2Valid && mat2Ready;
  assign bFire    = biasValid && biasReady;
  assign oFire    = outValid && outReady;
  assign colEnd   = m2Fire && (stepCol == LANE_W'(CHUNK_LANES - 1));
  assign lastStep = m2Fire && (kCount == bTot - DIMW'(1));
  assign subEnd   = m1Fire && (wrRow == ROW_W'(TILE_ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      tilesLeft <= '0;
      subsLeft  <= '0;
      bTot      <= '0;
      kCount    <= '0;
      halfFull  <= '0;
      wrHalf    <= 1'b0;
      rdHalf    <= 1'b0;
      wrRow     <= '0;
      outRow    <= '0;
      stepCol   <= '0;
      firstStep <= 1'b1;
      biasEnQ   <= 1'b0;
      fracQ     <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase     <= PH_STEP;
            tilesLeft <= tilesCalc;
            subsLeft  <= subsCalc;
            bTot      <= bTotal;
            biasEnQ   <= biasEn;
            fracQ     <= fracShift;
            halfFull  <= '0;
            wrHalf    <= 1'b0;
            rdHalf    <= 1'b0;
            wrRow     <= '0;
            stepCol   <= '0;
            kCount    <= '0;
            outRow    <= '0;
            firstStep <= 1'b1;
          end
        end
        PH_STEP: begin
          if (m2Fire) begin
            firstStep <= 1'b0;
            stepCol   <= stepCol + LANE_W'(1);
            kCount    <= kCount + DIMW'(1);
            if (lastStep) begin
              kCount <= '0;
              phase  <= biasEnQ ? PH_BIAS : PH_DRAIN;
            end
          end
        end
        PH_BIAS: begin
          if (bFire) phase <= PH_DRAIN;
        end
        PH_DRAIN: begin
          if (oFire) begin
            outRow <= outRow + ROW_W'(1);
            if (outLast) begin
              outRow    <= '0;
              firstStep <= 1'b1;
              tilesLeft <= tilesLeft - CNTW'(1);
              if (tilesLeft == CNTW'(1)) begin
                phase <= PH_IDLE;
                doneQ <= 1'b1;
              end else begin
                phase <= PH_STEP;
              end
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase

      // sub-matrix loader, runs alongside compute
      if (m1Fire) begin
        wrRow <= wrRow + ROW_W'(1);
        if (subEnd) begin
          wrRow    <= '0;
          wrHalf   <= ~wrHalf;
          subsLeft <= subsLeft - CNTW'(1);
        end
      end
      if (colEnd) rdHalf <= ~rdHalf;
      for (int h = 0; h < 2; h++) begin
        if (subEnd && (wrHalf == h[0])) halfFull[h] <= 1'b1;
        else if (colEnd && (rdHalf == h[0])) halfFull[h] <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrl.loadEn    = m1Fire;
    ctrl.loadHalf  = wrHalf;
    ctrl.loadRow   = wrRow;
    ctrl.stepEn    = m2Fire;
    ctrl.stepFirst = firstStep;
    ctrl.stepHalf  = rdHalf;
    ctrl.stepCol   = stepCol;
    ctrl.biasAdd   = bFire;
    ctrl.outRow    = outRow;
    ctrl.fracShift = fracQ;
  end
endmodule

// File: rtl/mmt_tile_engine.sv
module mmt_tile_engine import mmt_pkg::*; #(
  parameter int EW   = 16,
  parameter int ACCW = 40,
  parameter int DIMW = 16,
  localparam int CHW = CHUNK_LANES * EW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [DIMW-1:0] aTotal,
  input  logic [DIMW-1:0] bTotal,
  input  logic [DIMW-1:0] dTotal,
  input  logic [3:0]      fracShift,
  input  logic            biasEn,
  input  logic            mat1Valid,
  output logic            mat1Ready,
  input  logic [CHW-1:0]  mat1Data,
  input  logic            mat2Valid,
  output logic            mat2Ready,
  input  logic [CHW-1:0]  mat2Data,
  input  logic            biasValid,
  output logic            biasReady,
  input  logic [CHW-1:0]  biasData,
  output logic            outValid,
  input  logic            outReady,
  output logic [CHW-1:0]  outData,
  output logic            outLast,
  output logic            done
);
  ctrlStrobes_t ctrl;

  mmt_ctrl #(.DIMW(DIMW)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .aTotal(aTotal), .bTotal(bTotal), .dTotal(dTotal),
    .fracShift(fracShift), .biasEn(biasEn),
    .mat1Valid(mat1Valid), .mat1Ready(mat1Ready),
    .mat2Valid(mat2Valid), .mat2Ready(mat2Ready),
    .biasValid(biasValid), .biasReady(biasReady),
    .outValid(outValid), .outReady(outReady), .outLast(outLast),
    .done(done), .ctrl(ctrl)
  );

  mmt_datapath #(.EW(EW), .ACCW(ACCW)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .mat1Data(mat1Data), .mat2Data(mat2Data), .biasData(biasData),
    .outData(outData)
  );
endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
  parameter int CHW = 512
) (
  input logic           clk,
  input logic           rstN,
  input logic           mat2Ready,
  input logic           biasReady,
  input logic           outValid,
  input logic           outReady,
  input logic [CHW-1:0] outData,
  input logic           outLast,
  input logic           done
);
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  a_r10_no_step_in_drain: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !mat2Ready);

  a_r5_bias_phase_alone: assert property (@(posedge clk) disable iff (!rstN)
    biasReady |-> !mat2Ready && !outValid);

  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  a_r11_done_follows_last: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(outValid && outReady && outLast));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind mmt_tile_engine mmt_checker #(.CHW(CHW)) chk_i (
  .clk(clk), .rstN(rstN), .mat2Ready(mat2Ready), .biasReady(biasReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outLast(outLast), .done(done)
);

// File: tb/mmt_tile_engine_tb_top.sv
`timescale 1ns/1ps
module mmt_tile_engine_tb_top;
  localparam int MA = 16, MB = 96, MD = 64;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, biasEn = 1'b0;
  logic [15:0] aTotal = '0, bTotal = '0, dTotal = '0;
  logic [3:0] fracShift = '0;
  logic mat1Valid = 1'b0, mat2Valid = 1'b0, biasValid = 1'b0, outReady = 1'b0;
  logic [511:0] mat1Data = '0, mat2Data = '0, biasData = '0;
  logic mat1Ready, mat2Ready, biasReady, outValid, outLast, done;
  logic [511:0] outData;

  always #4 clk = ~clk;

  mmt_tile_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .aTotal(aTotal), .bTotal(bTotal),
    .dTotal(dTotal), .fracShift(fracShift), .biasEn(biasEn),
    .mat1Valid(mat1Valid), .mat1Ready(mat1Ready), .mat1Data(mat1Data),
    .mat2Valid(mat2Valid), .mat2Ready(mat2Ready), .mat2Data(mat2Data),
    .biasValid(biasValid), .biasReady(biasReady), .biasData(biasData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .done(done)
  );

  int vectors = 0, miscompares = 0;
  int A, B, D, S;
  bit BE, running, finished;
  shortint m1 [MA][MB];
  shortint m2 [MB][MD];
  shortint bs [MD];
  int doneCount, cyc, m2Cnt, lastM2Cyc, gapViolations, biasSeen;

  task automatic check(bit ok, string req, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic shortint expZ(int r, int c);
    longint acc = 0;
    for (int k = 0; k < B; k++) acc += longint'(m1[r][k]) * longint'(m2[k][c]);
    if (BE) acc += longint'(bs[c]) <<< S;
    if (S > 0) acc += longint'(1) <<< (S - 1);
    acc = acc >>> S;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return shortint'(acc);
  endfunction

  task automatic push1(logic [511:0] d, int gap);
    while ($urandom_range(99) < gap) begin mat1Valid = 1'b0; @(negedge clk); end
    mat1Valid = 1'b1; mat1Data = d; #1;
    while (!mat1Ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic push2(logic [511:0] d, int gap);
    while ($urandom_range(99) < gap) begin mat2Valid = 1'b0; @(negedge clk); end
    mat2Valid = 1'b1; mat2Data = d; #1;
    while (!mat2Ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic pushB(logic [511:0] d, int gap);
    while ($urandom_range(99) < gap) begin biasValid = 1'b0; @(negedge clk); end
    biasValid = 1'b1; biasData = d; #1;
    while (!biasReady) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic feedMat1(int gap);
    int nrb = A / 8, ncb = D / 32;
    for (int t = 0; t < nrb * ncb; t++)
      for (int kb = 0; kb < B / 32; kb++)
        for (int r = 0; r < 8; r++) begin
          logic [511:0] d;
          for (int e = 0; e < 32; e++) d[e*16 +: 16] = m1[(t % nrb) * 8 + r][kb * 32 + e];
          push1(d, gap);
        end
    mat1Valid = 1'b0;
  endtask

  task automatic feedMat2(int gap);
    int nrb = A / 8, ncb = D / 32;
    for (int t = 0; t < nrb * ncb; t++)
      for (int k = 0; k < B; k++) begin
        logic [511:0] d;
        for (int e = 0; e < 32; e++) d[e*16 +: 16] = m2[k][(t / nrb) * 32 + e];
        push2(d, gap);
      end
    mat2Valid = 1'b0;
  endtask

  task automatic feedBias(int gap);
    int nrb = A / 8, ncb = D / 32;
    if (BE)
      for (int t = 0; t < nrb * ncb; t++) begin
        logic [511:0] d;
        for (int e = 0; e < 32; e++) d[e*16 +: 16] = bs[(t / nrb) * 32 + e];
        pushB(d, gap);
      end
    biasValid = 1'b0;
  endtask

  task automatic collect(int stall, string req);
    int nrb = A / 8, ncb = D / 32;
    for (int t = 0; t < nrb * ncb; t++)
      for (int r = 0; r < 8; r++) begin
        int bad = -1;
        shortint got = 0, want = 0;
        forever begin
          @(negedge clk);
          outReady = ($urandom_range(99) >= stall); #1;
          if (outValid && outReady) break;
        end
        for (int e = 0; e < 32; e++) begin
          shortint g = shortint'(outData[e*16 +: 16]);
          shortint w = expZ((t % nrb) * 8 + r, (t / nrb) * 32 + e);
          if (g != w && bad < 0) begin bad = e; got = g; want = w; end
        end
        check(bad < 0, req, got, want);
        check(outLast == (r == 7), "R7 outLast", outLast, (r == 7));
      end
    @(negedge clk); outReady = 1'b0; #1;
    check(done == 1'b1, "R11 done after final chunk", done, 1);
    @(negedge clk); #1;
    check(done == 1'b0, "R11 done one cycle", done, 0);
  endtask

  // port monitor: done pulses, Mat2 spacing, bias handshake
  initial forever begin
    @(negedge clk); #2;
    cyc++;
    if (running) begin
      if (done) doneCount++;
      if (biasReady) biasSeen++;
      if (mat2Valid && mat2Ready) begin
        if ((m2Cnt % B) != 0 && (cyc - lastM2Cyc) != 1) gapViolations++;
        lastM2Cyc = cyc;
        m2Cnt++;
      end
    end
  end

  task automatic runCase(int a, int b, int d, int s, bit be, int gap, int stall,
                         bit wantNoGap, string req);
    A = a; B = b; D = d; S = s; BE = be;
    doneCount = 0; m2Cnt = 0; gapViolations = 0; biasSeen = 0;
    @(negedge clk);
    aTotal = 16'(a); bTotal = 16'(b); dTotal = 16'(d);
    fracShift = 4'(s); biasEn = be; start = 1'b1; running = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      feedMat1(gap);
      feedMat2(gap);
      feedBias(gap);
      collect(stall, req);
    join
    running = 1'b0;
    check(doneCount == 1, "R11 one done per operation", doneCount, 1);
    if (wantNoGap) check(gapViolations == 0, "R9 back-to-back steps", gapViolations, 0);
    if (!be) check(biasSeen == 0, "R6 bias handshake silent", biasSeen, 0);
  endtask

  task automatic fillRandom(int lim);
    for (int i = 0; i < MA; i++) for (int k = 0; k < MB; k++)
      m1[i][k] = shortint'($urandom_range(2 * lim) - lim);
    for (int k = 0; k < MB; k++) for (int j = 0; j < MD; j++)
      m2[k][j] = shortint'($urandom_range(2 * lim) - lim);
    for (int j = 0; j < MD; j++) bs[j] = shortint'($urandom_range(2 * lim) - lim);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    check(!mat1Ready && !mat2Ready && !biasReady && !outValid && !outLast && !done,
          "R1 reset state", {mat1Ready, mat2Ready, biasReady, outValid, done}, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    check(!mat1Ready && !mat2Ready && !biasReady && !outValid && !done,
          "R1 idle after reset", {mat1Ready, mat2Ready, biasReady, outValid, done}, 0);

    // directed small values, one tile, gapless (R2 R3)
    fillRandom(20);
    runCase(8, 32, 32, 0, 1'b0, 0, 0, 1'b1, "R3 single tile");

    // saturation of both polarities (R4)
    for (int i = 0; i < MA; i++) for (int k = 0; k < MB; k++) m1[i][k] = 32767;
    for (int k = 0; k < MB; k++) for (int j = 0; j < MD; j++) m2[k][j] = (j < 16) ? 32767 : -32768;
    runCase(8, 32, 32, 0, 1'b0, 10, 20, 1'b0, "R4 saturate");

    // round-half cases with shift 1 plus a small bias (R4 R5)
    for (int i = 0; i < MA; i++) for (int k = 0; k < MB; k++) m1[i][k] = (k == 0) ? 1 : 0;
    for (int k = 0; k < MB; k++) for (int j = 0; j < MD; j++) m2[k][j] = (k == 0) ? shortint'(j - 16) : 0;
    for (int j = 0; j < MD; j++) bs[j] = shortint'((j % 3) - 1);
    runCase(8, 32, 32, 1, 1'b1, 0, 0, 1'b0, "R5 round and bias");

    // random multi-tile, multi-block with bias and bubbles (R2 R3 R5 R7 R8)
    fillRandom(2000);
    runCase(16, 96, 64, 12, 1'b1, 30, 40, 1'b0, "R5 random with bias");

    // gapless multi-block without bias: ping-pong keeps steps back to back (R9 R6)
    fillRandom(300);
    runCase(8, 96, 64, 4, 1'b0, 0, 0, 1'b1, "R9 gapless");

    // random without bias, heavy back-pressure (R8 R10)
    fillRandom(1000);
    runCase(16, 64, 32, 8, 1'b0, 20, 70, 1'b0, "R8 back-pressure");

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++; miscompares++;
      $display("FAIL R11 watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule